// File: doc/BRIEF.md
# Multi-Function Power State Arbiter

This block holds the power-management state of three bus functions that live in one device and works out the state the device as a whole must keep. Each function's state is set by configuration writes to that function's power control register. The device stays at the highest-power state that any function asks for. A function that has left D0 has its target (memory and I/O) decoding switched off, and it still accepts configuration cycles. A write that takes a function from D3 back to D0 sends a single-cycle pulse that reinitializes that function's configuration registers.

Each function also has a wake enable bit and a wake status bit. A wake event can name the function it belongs to, or it can be marked as unattributed, and then every function's status bit is set. The shared wake output is high while any function has both its status bit and its enable bit set. The auxiliary-current capability field can be written only from the processor side. No host path reaches it.

Power states are encoded on two bits as D0=0, D1=1, D2=2 and D3=3, and a lower code means a higher-power state. Function indices are 0 to 2.

Top module: `pm_state_arbiter`

## Requirements
- R1: After a synchronous reset, every function is in D0 (code 0) and the device state is D0. All decode enables are 1, all wake enable bits and wake status bits are 0, reinit is 0, pme_out is 0 and aux_cap is 0.
- R2: A configuration write (cfg_wr=1) to function cfg_fn loads cfg_state into that function's state, and fn_state[2f+1:2f] shows the new state after the clock edge. The other functions keep their states.
- R3: dev_state equals the lowest code held by any of the three functions, because D0 is the highest-power state.
- R4: decode_en[f] is 1 exactly when function f is in D0. In any other state only configuration access reaches that function.
- R5: A write that moves function f from D3 to D0 raises reinit[f] for exactly one cycle after that edge. Every other transition, including D2 to D0 and D3 to D3, gives no pulse.
- R6: Every configuration write to function f loads cfg_pme_en into pme_en[f]. pme_en and pme_status keep their values across a reinitialization.
- R7: A wake event with wake_known=1 sets pme_status[wake_fn] only. An event that names index 3 changes nothing.
- R8: A wake event with wake_known=0 sets pme_status on all three functions.
- R9: A configuration write with cfg_pme_clr=1 clears pme_status[cfg_fn]. If a wake event sets the same bit in the same cycle, the bit stays set.
- R10: pme_out is 1 exactly when some function has both pme_status and pme_en set.
- R11: aux_cap loads proc_aux_val when proc_aux_wr=1. Configuration writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write to a power control register |
| cfg_fn | input | 2 | Target function index of the write |
| cfg_state | input | 2 | Requested power state |
| cfg_pme_en | input | 1 | New wake enable value |
| cfg_pme_clr | input | 1 | Write-1-to-clear for the wake status bit |
| wake_valid | input | 1 | Wake event strobe |
| wake_known | input | 1 | Event names a function |
| wake_fn | input | 2 | Function the event belongs to |
| proc_aux_wr | input | 1 | Processor-side write of the aux-current field |
| proc_aux_val | input | 3 | Aux-current value |
| dev_state | output | 2 | Device-level power state |
| fn_state | output | 6 | Per-function state, function f at bits 2f+1:2f |
| decode_en | output | 3 | Per-function target decode enable |
| pme_en | output | 3 | Per-function wake enable bits |
| pme_status | output | 3 | Per-function wake status bits |
| pme_out | output | 1 | Wake request to the host |
| reinit | output | 3 | Per-function configuration reinit pulse |
| aux_cap | output | 3 | Aux-current capability field |

## Verification
If a function's stored state is wrong, the error shows one cycle after the write, on fn_state and decode_en. It also shows on dev_state whenever that function holds the lowest code. A wrong status or enable bit shows on pme_status and pme_en in the cycle after the event, and on pme_out whenever the matching enable is set. A missing or stretched reinit pulse shows in the single cycle after a D3-to-D0 write. The scoreboard therefore compares every output in every cycle after reset.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int PM_NUM_FN = 3;
    localparam int PM_ST_W   = 2;
    localparam int PM_FN_W   = 2;
    localparam int PM_AUX_W  = 3;

    typedef enum logic [PM_ST_W-1:0] {
        PM_D0 = 2'd0,
        PM_D1 = 2'd1,
        PM_D2 = 2'd2,
        PM_D3 = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic                  wr;
        logic [PM_ST_W-1:0]    state;
        logic                  pme_en;
        logic                  pme_clr;
    } pm_cfg_wr_t;

    function automatic logic [PM_ST_W-1:0] pm_higher(
        input logic [PM_ST_W-1:0] a,
        input logic [PM_ST_W-1:0] b
    );
        return (a < b) ? a : b;
    endfunction

    function automatic logic pm_wakes_from_d3(
        input logic [PM_ST_W-1:0] cur,
        input logic [PM_ST_W-1:0] nxt
    );
        return (cur == PM_D3) && (nxt == PM_D0);
    endfunction

endpackage

// File: rtl/pm_func_slot.sv
module pm_func_slot
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  pm_cfg_wr_t         cfg,
    input  logic               wake_set,
    output logic [PM_ST_W-1:0] state_o,
    output logic               pme_en_o,
    output logic               pme_stat_o,
    output logic               reinit_o
);
    pm_state_e state_q;
    logic      pme_en_q;
    logic      pme_stat_q;
    logic      reinit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PM_D0;
            pme_en_q   <= 1'b0;
            pme_stat_q <= 1'b0;
            reinit_q   <= 1'b0;
        end else begin
            reinit_q   <= cfg.wr && pm_wakes_from_d3(state_q, cfg.state);
            if (cfg.wr) begin
                state_q  <= pm_state_e'(cfg.state);
                pme_en_q <= cfg.pme_en;
            end
            pme_stat_q <= wake_set | (pme_stat_q & ~(cfg.wr & cfg.pme_clr));
        end
    end

    assign state_o    = state_q;
    assign pme_en_o   = pme_en_q;
    assign pme_stat_o = pme_stat_q;
    assign reinit_o   = reinit_q;

    // R5: the reinit pulse lasts a single cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        reinit_q |=> !reinit_q);
    // R5: a pulse only follows a D3 to D0 move
    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        reinit_q |-> ($past(state_q) == PM_D3 && state_q == PM_D0));
    // R6: the enable bit changes only through a write
    a_r6_en_held: assert property (@(posedge clk) disable iff (rst)
        !cfg.wr |=> $stable(pme_en_q));
    // R9: a wake event wins over a clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        wake_set |=> pme_stat_q);

endmodule

// File: rtl/pm_wake_route.sv
module pm_wake_route
    import pm_pkg::*;
#(
    parameter int NFN = PM_NUM_FN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wake_valid,
    input  logic               wake_known,
    input  logic [PM_FN_W-1:0] wake_fn,
    output logic [NFN-1:0]     set_vec
);
    for (genvar g = 0; g < NFN; g++) begin : g_route
        assign set_vec[g] = wake_valid &&
                            (!wake_known || (wake_fn == PM_FN_W'(g)));
    end

    // R8: an unattributed event reaches every function
    a_r8_broadcast: assert property (@(posedge clk) disable iff (rst)
        (wake_valid && !wake_known) |-> (&set_vec));
    // R7: an attributed event reaches at most one function
    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        (wake_valid && wake_known) |-> $onehot0(set_vec));

endmodule

// File: rtl/pm_dev_merge.sv
module pm_dev_merge
    import pm_pkg::*;
#(
    parameter int NFN = PM_NUM_FN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NFN*PM_ST_W-1:0] fn_state,
    output logic [PM_ST_W-1:0]     dev_state,
    output logic [NFN-1:0]         decode_en
);
    logic [PM_ST_W-1:0] chain [NFN+1];

    assign chain[0] = PM_D3;
    for (genvar g = 0; g < NFN; g++) begin : g_merge
        assign chain[g+1]   = pm_higher(chain[g], fn_state[g*PM_ST_W +: PM_ST_W]);
        assign decode_en[g] = (fn_state[g*PM_ST_W +: PM_ST_W] == PM_D0);
    end
    assign dev_state = chain[NFN];

    // R3: the device never sits below any function's power
    for (genvar g = 0; g < NFN; g++) begin : g_chk
        a_r3_dev_not_lower: assert property (@(posedge clk) disable iff (rst)
            dev_state <= fn_state[g*PM_ST_W +: PM_ST_W]);
        // R4: a decoding function forces the device to D0
        a_r4_decode_dev: assert property (@(posedge clk) disable iff (rst)
            decode_en[g] |-> (dev_state == PM_D0));
    end

endmodule

// File: rtl/pm_state_arbiter.sv
module pm_state_arbiter
    import pm_pkg::*;
#(
    parameter int NFN  = PM_NUM_FN,
    parameter int AUXW = PM_AUX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr,
    input  logic [PM_FN_W-1:0]     cfg_fn,
    input  logic [PM_ST_W-1:0]     cfg_state,
    input  logic                   cfg_pme_en,
    input  logic                   cfg_pme_clr,
    input  logic                   wake_valid,
    input  logic                   wake_known,
    input  logic [PM_FN_W-1:0]     wake_fn,
    input  logic                   proc_aux_wr,
    input  logic [AUXW-1:0]        proc_aux_val,
    output logic [PM_ST_W-1:0]     dev_state,
    output logic [NFN*PM_ST_W-1:0] fn_state,
    output logic [NFN-1:0]         decode_en,
    output logic [NFN-1:0]         pme_en,
    output logic [NFN-1:0]         pme_status,
    output logic                   pme_out,
    output logic [NFN-1:0]         reinit,
    output logic [AUXW-1:0]        aux_cap
);
    logic [NFN-1:0] wake_set;
    logic [AUXW-1:0] aux_q;

    pm_wake_route #(.NFN(NFN)) u_route (
        .clk        (clk),
        .rst        (rst),
        .wake_valid (wake_valid),
        .wake_known (wake_known),
        .wake_fn    (wake_fn),
        .set_vec    (wake_set)
    );

    for (genvar g = 0; g < NFN; g++) begin : g_fn
        pm_cfg_wr_t slot_cfg;
        assign slot_cfg.wr      = cfg_wr && (cfg_fn == PM_FN_W'(g));
        assign slot_cfg.state   = cfg_state;
        assign slot_cfg.pme_en  = cfg_pme_en;
        assign slot_cfg.pme_clr = cfg_pme_clr;

        pm_func_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .cfg        (slot_cfg),
            .wake_set   (wake_set[g]),
            .state_o    (fn_state[g*PM_ST_W +: PM_ST_W]),
            .pme_en_o   (pme_en[g]),
            .pme_stat_o (pme_status[g]),
            .reinit_o   (reinit[g])
        );
    end

    pm_dev_merge #(.NFN(NFN)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .fn_state  (fn_state),
        .dev_state (dev_state),
        .decode_en (decode_en)
    );

    assign pme_out = |(pme_status & pme_en);

    always_ff @(posedge clk) begin
        if (rst)              aux_q <= '0;
        else if (proc_aux_wr) aux_q <= proc_aux_val;
    end
    assign aux_cap = aux_q;

    // R11: the aux field moves only on a processor-side write
    a_r11_aux_proc_only: assert property (@(posedge clk) disable iff (rst)
        !proc_aux_wr |=> $stable(aux_cap));
    // R10: no wake request without an enabled function
    a_r10_pme_needs_en: assert property (@(posedge clk) disable iff (rst)
        pme_out |-> (pme_en != '0));

endmodule

// File: tb/pm_state_arbiter_bench.sv
module pm_state_arbiter_bench;
    typedef struct {
        logic [1:0] dev;
        logic [5:0] fst;
        logic [2:0] dec;
        logic [2:0] en;
        logic [2:0] stat;
        logic       pme;
        logic [2:0] rin;
        logic [2:0] aux;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, cfg_pme_en = 0, cfg_pme_clr = 0;
    logic [1:0] cfg_fn = 0, cfg_state = 0, wake_fn = 0;
    logic wake_valid = 0, wake_known = 0, proc_aux_wr = 0;
    logic [2:0] proc_aux_val = 0;
    logic [1:0] dev_state;
    logic [5:0] fn_state;
    logic [2:0] decode_en, pme_en, pme_status, reinit, aux_cap;
    logic pme_out;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    logic [1:0] m_st [3];
    logic [2:0] m_en = 0, m_stat = 0, m_aux = 0;

    always #10 clk = ~clk;

    pm_state_arbiter u_pm_state_arbiter (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fn(cfg_fn),
        .cfg_state(cfg_state), .cfg_pme_en(cfg_pme_en), .cfg_pme_clr(cfg_pme_clr),
        .wake_valid(wake_valid), .wake_known(wake_known), .wake_fn(wake_fn),
        .proc_aux_wr(proc_aux_wr), .proc_aux_val(proc_aux_val),
        .dev_state(dev_state), .fn_state(fn_state), .decode_en(decode_en),
        .pme_en(pme_en), .pme_status(pme_status), .pme_out(pme_out),
        .reinit(reinit), .aux_cap(aux_cap)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] fn, input logic [1:0] s,
                        input logic pe, input logic clr, input logic wv,
                        input logic wk, input logic [1:0] wf,
                        input logic aw, input logic [2:0] av);
        exp_t e;
        logic [2:0] rin, setv, clrv;
        logic [1:0] best;
        @(negedge clk);
        cfg_wr = wr; cfg_fn = fn; cfg_state = s; cfg_pme_en = pe; cfg_pme_clr = clr;
        wake_valid = wv; wake_known = wk; wake_fn = wf;
        proc_aux_wr = aw; proc_aux_val = av;
        rin = 0; clrv = 0; setv = 0;
        if (wr && fn < 3) begin
            if (m_st[fn] == 2'd3 && s == 2'd0) rin[fn] = 1'b1;
            m_st[fn] = s;
            m_en[fn] = pe;
            if (clr) clrv[fn] = 1'b1;
        end
        if (wv) begin
            if (!wk) setv = 3'b111;
            else if (wf < 3) setv[wf] = 1'b1;
        end
        m_stat = setv | (m_stat & ~clrv);
        if (aw) m_aux = av;
        best = 2'd3;
        for (int i = 0; i < 3; i++) if (m_st[i] < best) best = m_st[i];
        e.dev = best;
        e.fst = {m_st[2], m_st[1], m_st[0]};
        for (int i = 0; i < 3; i++) e.dec[i] = (m_st[i] == 2'd0);
        e.en = m_en; e.stat = m_stat; e.pme = |(m_en & m_stat);
        e.rin = rin; e.aux = m_aux;
        q.push_back(e);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        #5;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R3 dev_state", 8'(dev_state), 8'(e.dev));
            chk("R2 fn_state", 8'(fn_state), 8'(e.fst));
            chk("R4 decode_en", 8'(decode_en), 8'(e.dec));
            chk("R6 pme_en", 8'(pme_en), 8'(e.en));
            chk("R7/R8/R9 pme_status", 8'(pme_status), 8'(e.stat));
            chk("R10 pme_out", 8'(pme_out), 8'(e.pme));
            chk("R5 reinit", 8'(reinit), 8'(e.rin));
            chk("R11 aux_cap", 8'(aux_cap), 8'(e.aux));
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_st[i] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 dev_state", 8'(dev_state), 8'd0);
        chk("R1 fn_state", 8'(fn_state), 8'd0);
        chk("R1 decode_en", 8'(decode_en), 8'h7);
        chk("R1 pme bits", 8'({pme_en, pme_status}), 8'd0);
        chk("R1 pme_out/reinit/aux", 8'({pme_out, reinit, aux_cap}), 8'd0);
        idle();
        step(1, 1, 3, 1, 0, 0, 0, 0, 0, 0);   // R2 fn1 -> D3, others still D0
        step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0);   // R3 fn0 -> D2
        step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0);   // R3 dev now D1
        step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0);   // R3 dev now D2
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);   // R8 unattributed wake, R10 pme via fn1
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);   // R5 D3->D0 pulse, R6 bits preserved
        idle();                               // R5 pulse drops
        step(1, 1, 0, 1, 1, 1, 1, 1, 0, 0);   // R9 set wins over clear
        step(1, 1, 0, 1, 1, 0, 0, 0, 0, 0);   // R9 clear
        step(1, 0, 2, 0, 1, 0, 0, 0, 0, 0);   // R9 clear fn0
        step(1, 2, 3, 0, 1, 0, 0, 0, 0, 0);   // R5 D3->D3 no pulse, clears fn2
        step(0, 0, 0, 0, 0, 1, 1, 3, 0, 0);   // R7 index 3 dropped
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);   // R7 attributed to fn0
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // R5 D2->D0 no pulse, R10 pme
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);   // R5 fn2 D3->D0 pulse
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 5);   // R11 processor write
        step(1, 0, 3, 0, 0, 0, 0, 0, 0, 0);   // R11 config write leaves aux, R10 pme off
        step(1, 1, 1, 0, 0, 1, 1, 2, 0, 0);   // R4 fn1 leaves D0, R7 fn2 status
        idle();
        idle();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule